// File: doc/BRIEF.md
# Multi-View Floating-Point Register Bank

This block holds sixty-four 32-bit floating-point registers in a single storage array. The same storage can be reached through four views, chosen on each access. The word view reaches one register. The pair view reaches two neighbouring registers as one 64-bit value. The quad view addresses the first register of a group of four. The block view addresses the first register of a group of sixteen. The block only translates indices and joins or splits words. It does no floating-point arithmetic.

There is one access port. It has a view select, a 6-bit index, a write enable and 64-bit write data. The read result is combinational from the current view and index. Writes commit on the rising clock edge. A synchronous active-high reset clears every register.

Top module: `fpbank_multiview`

## Requirements
- R1: While reset is high, a rising edge clears all 64 registers to zero. After reset, every view reads zero until a write occurs.
- R2: The view select uses these codes: 0 = word, 1 = pair, 2 = quad, 3 = block. In the word, quad and block views, the register value appears on read bits 31:0 and bits 63:32 read zero.
- R3: A word-view write stores write-data bits 31:0 into the register at the index on the rising edge. Write-data bits 63:32 have no effect.
- R4: A pair-view read at index n returns register n on bits 63:32 and register n+1 on bits 31:0.
- R5: A pair-view write at index n stores write-data bits 63:32 into register n and bits 31:0 into register n+1, both on the same rising edge.
- R6: In the pair view at index 63, the second word is register 0, for both reads and writes.
- R7: The quad view uses only index bits 3:0 and reaches register (index[3:0] × 4). Index bits 5:4 have no effect.
- R8: The block view uses only index bits 1:0 and reaches register (index[1:0] × 16). Index bits 5:2 have no effect.
- R9: With write enable low, a clock edge leaves every register unchanged.
- R10: The read data follows a change of view or index in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_view | input | 2 | View select (0 word, 1 pair, 2 quad, 3 block) |
| acc_idx | input | 6 | Access index, masked and scaled per view |
| acc_we | input | 1 | Write enable |
| acc_wdata | input | 64 | Write data; only bits 31:0 are used outside the pair view |
| acc_rdata | output | 64 | Combinational read data |

## Verification
Suppose the index mapping is wrong, for example a bad scale, a mask that is too wide, or a missing pair wrap. The value written through one view would then come back at the wrong place when read through another view. A cross-view read in the next low clock phase shows this. Suppose the two write lanes commit in different cycles, or swap their words. A pair write read back as two single words, one cycle later, shows the mismatch at both halves. A leaking write enable changes a value that should stay stable across an idle edge, and the checker sees that on that edge.

// File: rtl/fpbank_pkg.sv
package fpbank_pkg;

    localparam int FB_WORD     = 32;
    localparam int FB_NREG     = 64;
    localparam int FB_IW       = $clog2(FB_NREG);
    localparam int FB_QUAD     = 4;
    localparam int FB_BLOCK    = 16;
    localparam int FB_QUAD_SH  = $clog2(FB_QUAD);
    localparam int FB_BLOCK_SH = $clog2(FB_BLOCK);
    localparam int FB_QUAD_MB  = FB_IW - FB_QUAD_SH;
    localparam int FB_BLOCK_MB = FB_IW - FB_BLOCK_SH;

    typedef enum logic [1:0] {
        VIEW_WORD  = 2'd0,
        VIEW_PAIR  = 2'd1,
        VIEW_QUAD  = 2'd2,
        VIEW_BLOCK = 2'd3
    } view_e;

    typedef struct packed {
        logic [FB_IW-1:0] lead;
        logic [FB_IW-1:0] tail;
        logic             pair;
    } slot_map_t;

    typedef struct packed {
        logic               we_lead;
        logic               we_tail;
        logic [FB_WORD-1:0] d_lead;
        logic [FB_WORD-1:0] d_tail;
    } wr_lanes_t;

    function automatic logic [FB_IW-1:0] quad_base(input logic [FB_IW-1:0] idx);
        return {idx[FB_QUAD_MB-1:0], {FB_QUAD_SH{1'b0}}};
    endfunction

    function automatic logic [FB_IW-1:0] block_base(input logic [FB_IW-1:0] idx);
        return {idx[FB_BLOCK_MB-1:0], {FB_BLOCK_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/fpbank_addr_map.sv
module fpbank_addr_map
    import fpbank_pkg::*;
(
    input  view_e            view,
    input  logic [FB_IW-1:0] idx,
    output slot_map_t        map
);
    always_comb begin
        map.pair = 1'b0;
        map.lead = idx;
        unique case (view)
            VIEW_WORD:  map.lead = idx;
            VIEW_PAIR:  begin
                map.lead = idx;
                map.pair = 1'b1;
            end
            VIEW_QUAD:  map.lead = quad_base(idx);
            VIEW_BLOCK: map.lead = block_base(idx);
            default:    map.lead = idx;
        endcase
        // second word of a pair wraps modulo the bank size
        map.tail = map.lead + FB_IW'(1);
    end
endmodule

// File: rtl/fpbank_wr_split.sv
module fpbank_wr_split
    import fpbank_pkg::*;
(
    input  logic                 we,
    input  slot_map_t            map,
    input  logic [2*FB_WORD-1:0] wdata,
    output wr_lanes_t            lanes
);
    always_comb begin
        lanes.we_lead = we;
        lanes.we_tail = we & map.pair;
        if (map.pair) begin
            lanes.d_lead = wdata[2*FB_WORD-1:FB_WORD];
            lanes.d_tail = wdata[FB_WORD-1:0];
        end else begin
            lanes.d_lead = wdata[FB_WORD-1:0];
            lanes.d_tail = '0;
        end
    end
endmodule

// File: rtl/fpbank_store.sv
module fpbank_store #(
    parameter int NREG = 64,
    parameter int WORD = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we_lead,
    input  logic [IW-1:0]   ix_lead,
    input  logic [WORD-1:0] d_lead,
    input  logic            we_tail,
    input  logic [IW-1:0]   ix_tail,
    input  logic [WORD-1:0] d_tail,
    output logic [WORD-1:0] q_lead,
    output logic [WORD-1:0] q_tail
);
    logic [WORD-1:0] cells [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= '0;
            end else if (we_lead && ix_lead == IW'(g)) begin
                cells[g] <= d_lead;
            end else if (we_tail && ix_tail == IW'(g)) begin
                cells[g] <= d_tail;
            end
        end
    end

    assign q_lead = cells[ix_lead];
    assign q_tail = cells[ix_tail];
endmodule

// File: rtl/fpbank_multiview.sv
module fpbank_multiview
    import fpbank_pkg::*;
#(
    parameter int NREG = FB_NREG,
    parameter int WORD = FB_WORD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           acc_view,
    input  logic [5:0]           acc_idx,
    input  logic                 acc_we,
    input  logic [2*FB_WORD-1:0] acc_wdata,
    output logic [2*FB_WORD-1:0] acc_rdata
);
    slot_map_t          map;
    wr_lanes_t          lanes;
    logic [FB_WORD-1:0] q_lead;
    logic [FB_WORD-1:0] q_tail;

    fpbank_addr_map u_map (
        .view (view_e'(acc_view)),
        .idx  (acc_idx),
        .map  (map)
    );

    fpbank_wr_split u_split (
        .we    (acc_we),
        .map   (map),
        .wdata (acc_wdata),
        .lanes (lanes)
    );

    fpbank_store #(.NREG(NREG), .WORD(WORD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we_lead (lanes.we_lead),
        .ix_lead (map.lead),
        .d_lead  (lanes.d_lead),
        .we_tail (lanes.we_tail),
        .ix_tail (map.tail),
        .d_tail  (lanes.d_tail),
        .q_lead  (q_lead),
        .q_tail  (q_tail)
    );

    always_comb begin
        if (map.pair) acc_rdata = {q_lead, q_tail};
        else          acc_rdata = {{FB_WORD{1'b0}}, q_lead};
    end
endmodule

// File: rtl/fpbank_chk.sv
module fpbank_chk
    import fpbank_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           acc_view,
    input logic [5:0]           acc_idx,
    input logic                 acc_we,
    input logic [2*FB_WORD-1:0] acc_wdata,
    input logic [2*FB_WORD-1:0] acc_rdata
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed) |-> (acc_rdata == '0));

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_view != VIEW_PAIR) |-> (acc_rdata[2*FB_WORD-1:FB_WORD] == '0));

    // R3
    word_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(acc_we) && $past(acc_view) == VIEW_WORD &&
         acc_view == VIEW_WORD && acc_idx == $past(acc_idx))
        |-> (acc_rdata[FB_WORD-1:0] == $past(acc_wdata[FB_WORD-1:0])));

    // R5
    pair_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(acc_we) && $past(acc_view) == VIEW_PAIR &&
         acc_view == VIEW_PAIR && acc_idx == $past(acc_idx))
        |-> (acc_rdata == $past(acc_wdata)));

    // R6
    pair_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(acc_we) && $past(acc_view) == VIEW_PAIR &&
         $past(acc_idx) == 6'd63 && acc_view == VIEW_WORD && acc_idx == 6'd0)
        |-> (acc_rdata[FB_WORD-1:0] == $past(acc_wdata[FB_WORD-1:0])));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(acc_we) && $stable(acc_view) && $stable(acc_idx))
        |-> $stable(acc_rdata));
endmodule

bind fpbank_multiview fpbank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_view  (acc_view),
    .acc_idx   (acc_idx),
    .acc_we    (acc_we),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata)
);

// File: tb/fpbank_multiview_tb.sv
`timescale 1ns/1ps
module fpbank_multiview_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_view = 2'd0;
    logic [5:0]  acc_idx = 6'd0;
    logic        acc_we = 1'b0;
    logic [63:0] acc_wdata = 64'd0;
    logic [63:0] acc_rdata;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fpbank_multiview u_dut (
        .clk(clk), .rst(rst), .acc_view(acc_view), .acc_idx(acc_idx),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
    );

    typedef struct packed {
        logic [1:0]  view;
        logic [5:0]  idx;
        logic        we;
        logic [63:0] wd;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 6'd5,  1'b1, 64'h11111111_22222222, 64'h0, 4'd5},  // R5 write
        '{2'd0, 6'd5,  1'b0, 64'h0, 64'h00000000_11111111, 4'd5},  // R5
        '{2'd0, 6'd6,  1'b0, 64'h0, 64'h00000000_22222222, 4'd5},  // R5
        '{2'd1, 6'd5,  1'b0, 64'h0, 64'h11111111_22222222, 4'd4},  // R4
        '{2'd1, 6'd63, 1'b1, 64'hAAAA0001_BBBB0002, 64'h0, 4'd6},  // R6 write
        '{2'd0, 6'd63, 1'b0, 64'h0, 64'h00000000_AAAA0001, 4'd6},  // R6
        '{2'd0, 6'd0,  1'b0, 64'h0, 64'h00000000_BBBB0002, 4'd6},  // R6
        '{2'd1, 6'd63, 1'b0, 64'h0, 64'hAAAA0001_BBBB0002, 4'd6},  // R6
        '{2'd0, 6'd9,  1'b1, 64'hFFFFFFFF_12345678, 64'h0, 4'd3},  // R3 write
        '{2'd0, 6'd9,  1'b0, 64'h0, 64'h00000000_12345678, 4'd3},  // R3
        '{2'd1, 6'd8,  1'b0, 64'h0, 64'h00000000_12345678, 4'd4},  // R4
        '{2'd2, 6'h37, 1'b1, 64'h0BAD0000_CAFE0007, 64'h0, 4'd7},  // R7 write
        '{2'd0, 6'd28, 1'b0, 64'h0, 64'h00000000_CAFE0007, 4'd7},  // R7
        '{2'd2, 6'h07, 1'b0, 64'h0, 64'h00000000_CAFE0007, 4'd7},  // R7
        '{2'd3, 6'h2E, 1'b1, 64'h0000FFFF_DEAD0032, 64'h0, 4'd8},  // R8 write
        '{2'd0, 6'd32, 1'b0, 64'h0, 64'h00000000_DEAD0032, 4'd8},  // R8
        '{2'd3, 6'h02, 1'b0, 64'h0, 64'h00000000_DEAD0032, 4'd8},  // R8
        '{2'd2, 6'h08, 1'b0, 64'h0, 64'h00000000_DEAD0032, 4'd2},  // R2
        '{2'd0, 6'd9,  1'b0, 64'hEEEEEEEE_EEEEEEEE, 64'h0, 4'd0},  // R9 idle edge
        '{2'd0, 6'd9,  1'b0, 64'h0, 64'h00000000_12345678, 4'd9}   // R9
    };

    task automatic check(input string tag, input logic [63:0] exp);
        n_run++;
        if (acc_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, acc_rdata, exp);
        end
    endtask

    task automatic drive(input logic [1:0] v, input logic [5:0] i,
                         input logic w, input logic [63:0] d);
        @(negedge clk);
        acc_view = v; acc_idx = i; acc_we = w; acc_wdata = d;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: everything zero after reset
        drive(2'd1, 6'd0, 1'b0, 64'h0);  check("R1 pair 0", 64'h0);
        drive(2'd1, 6'd40, 1'b0, 64'h0); check("R1 pair 40", 64'h0);
        drive(2'd3, 6'd3, 1'b0, 64'h0);  check("R1 block 3", 64'h0);

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].view, TBL[k].idx, TBL[k].we, TBL[k].wd);
            if (!TBL[k].we && TBL[k].req != 4'd0)
                check($sformatf("R%0d vector %0d", TBL[k].req, k), TBL[k].exp);
        end

        // R10: read follows index without a clock edge
        @(negedge clk);
        acc_we = 1'b0; acc_view = 2'd0; acc_idx = 6'd5; #0.5;
        check("R10 idx 5", 64'h00000000_11111111);
        acc_idx = 6'd6; #0.5;
        check("R10 idx 6", 64'h00000000_22222222);
        acc_view = 2'd1; acc_idx = 6'd5; #0.5;
        check("R10 view change", 64'h11111111_22222222);

        // R7: index bits 5:4 do not move a quad write
        drive(2'd2, 6'h3F, 1'b1, 64'h0000_0000_5EED0015);
        drive(2'd0, 6'd60, 1'b0, 64'h0); check("R7 quad 15", 64'h00000000_5EED0015);

        // R1: reset again clears written registers
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        drive(2'd0, 6'd9, 1'b0, 64'h0);  check("R1 reg 9 after reset", 64'h0);
        drive(2'd1, 6'd63, 1'b0, 64'h0); check("R1 pair 63 after reset", 64'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule